// File: doc/BRIEF.md
# Fixed-Latency Memory Response Emulator

This block stands in for external memory when a cache or memory controller is tested. It accepts block-sized read and write requests on a request channel that has a ready signal. A write goes straight into a small internal backing array and produces no reply. A read captures the addressed block at the moment it is accepted and parks it, together with its tag, in a bounded pending table with a countdown set to a fixed latency.

Every cycle, each pending countdown that is still above zero drops by one. Among the entries that have reached zero, the one nearest the front of the table is offered on a valid/ready response channel. The table is kept in arrival order, so this is always the oldest. The offer stays unchanged until the consumer takes it, and then the entry is removed and the table compacts.

Request readiness is taken away whenever the table is full. When the periodic stall switch is on, it is also taken away on one cycle out of every stall period. Readiness is computed from registered state only, so it is settled before any request is sampled.

Top module: `mlat_mem_emu`

## Requirements
- R1: A read accepted at clock edge k (req_rd high and req_ready high in the cycle before edge k) makes rsp_valid rise after edge k+LATENCY at the earliest, and no earlier, when no older response is waiting.
- R2: The data of a read response is the content of the addressed block at the edge where the read was accepted; writes accepted later do not change it.
- R3: An accepted write replaces the addressed block, which is word w at bits [w*WORD_W +: WORD_W], and creates no table entry and no response.
- R4: At most one response is offered per cycle: the lowest-index entry whose countdown is zero. Since the table is in arrival order, responses come out in the order their reads were accepted, and rsp_tag equals the tag of that read.
- R5: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_tag and rsp_data hold, and the entry stays in the table. Countdowns of the other entries keep running.
- R6: req_ready is low in any cycle where the table holds DEPTH entries. A request presented while req_ready is low is ignored: it writes nothing and creates no entry.
- R7: With STALL_EN set, req_ready is low in every cycle whose count since reset is a multiple of STALL_PERIOD. The first cycle after reset is count 0.
- R8: Reset empties the table (rsp_valid low), clears the cycle count and sets every block of the backing array to zero.
- R9: When a read and a write to the same block are accepted in the same cycle, the read returns the block as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_idx | input | IDX_W | Block index in the backing array |
| req_tag | input | TAG_W | Tag returned with the read response |
| req_wdata | input | BLK_WORDS*WORD_W | Write block, word w at bits [w*WORD_W +: WORD_W] |
| req_ready | output | 1 | Requests are taken in this cycle |
| rsp_valid | output | 1 | A read response is offered |
| rsp_tag | output | TAG_W | Tag of the offered response |
| rsp_data | output | BLK_WORDS*WORD_W | Block captured when the read was accepted |
| rsp_ready | input | 1 | Consumer takes the offered response |

## Verification
The bench builds the block with LATENCY 6, DEPTH 4, STALL_PERIOD 8, two 16-bit words per block, eight blocks and 4-bit tags, with the periodic stall on. With this short latency and shallow table, a few cycles of rsp_ready low fill the table. Periodic stalls then land both on an empty table and on a full one, and the countdowns expire while an older response is held. A lockstep model written from the requirements predicts req_ready, rsp_valid, rsp_tag and rsp_data in every cycle. Directed runs cover same-block read and write, a write that follows a pending read, long response holds and a full table, and a seeded random mix covers the rest.

// File: rtl/mlat_pkg.sv
package mlat_pkg;

  // Saturating countdown step: stays at zero once expired.
  function automatic int unsigned count_step(input int unsigned c);
    return (c == 0) ? 0 : c - 1;
  endfunction

  // Next value of a wrapping phase counter modulo period.
  function automatic int unsigned phase_step(input int unsigned p, input int unsigned period);
    return (p + 1 >= period) ? 0 : p + 1;
  endfunction

  // Request readiness: a full table always blocks, the periodic slot blocks when enabled.
  function automatic logic ready_calc(input logic periodic_en, input logic phase_zero,
                                      input logic full);
    return !(full || (periodic_en && phase_zero));
  endfunction

endpackage

// File: rtl/mlat_pacer.sv
module mlat_pacer #(
  parameter int STALL_PERIOD = 16,
  parameter bit STALL_EN     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  output logic req_ready,
  output logic phase_zero
);
  localparam int PW = (STALL_PERIOD > 1) ? $clog2(STALL_PERIOD) : 1;

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= PW'(mlat_pkg::phase_step(32'(phase_q), 32'(STALL_PERIOD)));
  end

  assign phase_zero = (phase_q == '0);
  assign req_ready  = mlat_pkg::ready_calc(STALL_EN, phase_zero, full);

  generate
    if (STALL_PERIOD > 1) begin : g_phase_chk
      // R7: the stall slot lasts a single cycle before the phase moves on
      assert_slot_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_zero |=> !phase_zero);
    end
    if (STALL_EN) begin : g_stall_chk
      // R7: readiness is withdrawn in the periodic slot
      assert_slot_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_zero) |-> !req_ready);
    end
  endgenerate

endmodule

// File: rtl/mlat_store.sv
module mlat_store #(
  parameter int BLOCKS    = 16,
  parameter int BLK_WORDS = 4,
  parameter int WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(BLOCKS)-1:0]   wr_idx,
  input  logic [BLK_WORDS*WORD_W-1:0] wr_blk,
  input  logic [$clog2(BLOCKS)-1:0]   rd_idx,
  output logic [BLK_WORDS*WORD_W-1:0] rd_blk
);
  // One column of storage per word of the block.
  generate
    for (genvar w = 0; w < BLK_WORDS; w++) begin : g_col
      logic [WORD_W-1:0] col_q [BLOCKS];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int b = 0; b < BLOCKS; b++) col_q[b] <= '0;
        end else if (wr_en) begin
          col_q[wr_idx] <= wr_blk[w*WORD_W +: WORD_W];
        end
      end

      // Combinational read: a same-cycle write is not yet visible.
      assign rd_blk[w*WORD_W +: WORD_W] = col_q[rd_idx];
    end
  endgenerate

endmodule

// File: rtl/mlat_table.sv
module mlat_table #(
  parameter int DEPTH   = 16,
  parameter int LATENCY = 100,
  parameter int TAG_W   = 8,
  parameter int BLK_W   = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [TAG_W-1:0]           push_tag,
  input  logic [BLK_W-1:0]           push_data,
  input  logic                       rsp_ready,
  output logic                       rsp_valid,
  output logic [TAG_W-1:0]           rsp_tag,
  output logic [BLK_W-1:0]           rsp_data,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam int FW = $clog2(DEPTH + 1);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] ent_v_q, ent_v_d;
  logic [CW-1:0]    ent_cnt_q [DEPTH];
  logic [CW-1:0]    ent_cnt_d [DEPTH];
  logic [TAG_W-1:0] ent_tag_q [DEPTH];
  logic [TAG_W-1:0] ent_tag_d [DEPTH];
  logic [BLK_W-1:0] ent_dat_q [DEPTH];
  logic [BLK_W-1:0] ent_dat_d [DEPTH];
  logic [FW-1:0]    fill_q, fill_d, fill_after_pop;

  logic          sel_found;
  logic [SW-1:0] sel_idx;
  logic          pop_evt;

  // Oldest expired entry: scan downward so the lowest index wins.
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_v_q[i] && (ent_cnt_q[i] == '0)) begin
        sel_found = 1'b1;
        sel_idx   = SW'(i);
      end
    end
  end

  assign rsp_valid = sel_found;
  assign rsp_tag   = ent_tag_q[sel_idx];
  assign rsp_data  = ent_dat_q[sel_idx];
  assign pop_evt   = sel_found && rsp_ready;
  assign full      = (fill_q >= FW'(DEPTH));
  assign fill      = fill_q;
  assign fill_after_pop = fill_q - FW'(pop_evt);

  // Compact above the removed entry, step countdowns, append at the tail.
  always_comb begin
    int src;
    for (int i = 0; i < DEPTH; i++) begin
      src = i + ((pop_evt && (i >= int'(sel_idx))) ? 1 : 0);
      if (src < DEPTH) begin
        ent_v_d[i]   = ent_v_q[src];
        ent_cnt_d[i] = CW'(mlat_pkg::count_step(32'(ent_cnt_q[src])));
        ent_tag_d[i] = ent_tag_q[src];
        ent_dat_d[i] = ent_dat_q[src];
      end else begin
        ent_v_d[i]   = 1'b0;
        ent_cnt_d[i] = '0;
        ent_tag_d[i] = '0;
        ent_dat_d[i] = '0;
      end
      if (push && (FW'(i) == fill_after_pop)) begin
        ent_v_d[i]   = 1'b1;
        ent_cnt_d[i] = CW'(LATENCY);
        ent_tag_d[i] = push_tag;
        ent_dat_d[i] = push_data;
      end
    end
    fill_d = fill_after_pop + FW'(push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v_q <= '0;
      fill_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_cnt_q[i] <= '0;
        ent_tag_q[i] <= '0;
        ent_dat_q[i] <= '0;
      end
    end else begin
      ent_v_q <= ent_v_d;
      fill_q  <= fill_d;
      for (int i = 0; i < DEPTH; i++) begin
        ent_cnt_q[i] <= ent_cnt_d[i];
        ent_tag_q[i] <= ent_tag_d[i];
        ent_dat_q[i] <= ent_dat_d[i];
      end
    end
  end

  // R6: nothing is appended to a full table
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill_q < FW'(DEPTH)));

  // R5: an offered response is frozen until it is taken
  assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_data)));

  // R4: live entries always form a packed prefix counted by the fill level
  assert_packed_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ent_v_q) == int'(fill_q)) && ((ent_v_q & (ent_v_q + 1'b1)) == '0));

endmodule

// File: rtl/mlat_mem_emu.sv
module mlat_mem_emu #(
  parameter int LATENCY      = 100,
  parameter int DEPTH        = 16,
  parameter int STALL_PERIOD = 16,
  parameter bit STALL_EN     = 1'b1,
  parameter int BLK_WORDS    = 4,
  parameter int WORD_W       = 32,
  parameter int BLOCKS       = 16,
  parameter int TAG_W        = 8,
  localparam int IDX_W       = $clog2(BLOCKS),
  localparam int BLK_W       = BLK_WORDS * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rd,
  input  logic             req_wr,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [BLK_W-1:0] req_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [TAG_W-1:0] rsp_tag,
  output logic [BLK_W-1:0] rsp_data,
  input  logic             rsp_ready
);
  localparam int FW = $clog2(DEPTH + 1);

  logic          tbl_full;
  logic [FW-1:0] tbl_fill;
  logic          slot_zero;
  logic [BLK_W-1:0] rd_snapshot;

  // Named events for the checks below.
  logic take_rd, take_wr;
  assign take_rd = req_rd && req_ready;
  assign take_wr = req_wr && req_ready;

  mlat_pacer #(
    .STALL_PERIOD (STALL_PERIOD),
    .STALL_EN     (STALL_EN)
  ) pacer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .full       (tbl_full),
    .req_ready  (req_ready),
    .phase_zero (slot_zero)
  );

  mlat_store #(
    .BLOCKS    (BLOCKS),
    .BLK_WORDS (BLK_WORDS),
    .WORD_W    (WORD_W)
  ) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (take_wr),
    .wr_idx (req_idx),
    .wr_blk (req_wdata),
    .rd_idx (req_idx),
    .rd_blk (rd_snapshot)
  );

  mlat_table #(
    .DEPTH   (DEPTH),
    .LATENCY (LATENCY),
    .TAG_W   (TAG_W),
    .BLK_W   (BLK_W)
  ) table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (take_rd),
    .push_tag  (req_tag),
    .push_data (rd_snapshot),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_data  (rsp_data),
    .full      (tbl_full),
    .fill      (tbl_fill)
  );

  // R6: a full table withdraws readiness
  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full |-> !req_ready);

  // R3: a lone write never grows the table
  assert_write_no_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_wr && !req_rd) |=> (tbl_fill <= $past(tbl_fill)));

  // R4: a response on the port implies a non-empty table
  assert_rsp_needs_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (tbl_fill != '0));

endmodule

// File: tb/mlat_mem_emu_tb.sv
module mlat_mem_emu_tb_top;
  localparam int LAT = 6;
  localparam int DEP = 4;
  localparam int PER = 8;
  localparam int BWD = 2;
  localparam int WW  = 16;
  localparam int NBK = 8;
  localparam int TW  = 4;
  localparam int IW  = $clog2(NBK);
  localparam int BLKW = BWD * WW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_rd = 1'b0, req_wr = 1'b0, rsp_ready = 1'b0;
  logic [IW-1:0]   req_idx = '0;
  logic [TW-1:0]   req_tag = '0;
  logic [BLKW-1:0] req_wdata = '0;
  logic            req_ready, rsp_valid;
  logic [TW-1:0]   rsp_tag;
  logic [BLKW-1:0] rsp_data;

  always #2 clk = ~clk;

  mlat_mem_emu #(
    .LATENCY (LAT), .DEPTH (DEP), .STALL_PERIOD (PER), .STALL_EN (1'b1),
    .BLK_WORDS (BWD), .WORD_W (WW), .BLOCKS (NBK), .TAG_W (TW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .req_rd (req_rd), .req_wr (req_wr),
    .req_idx (req_idx), .req_tag (req_tag), .req_wdata (req_wdata),
    .req_ready (req_ready), .rsp_valid (rsp_valid), .rsp_tag (rsp_tag),
    .rsp_data (rsp_data), .rsp_ready (rsp_ready)
  );

  int vectors = 0;
  int miscompares = 0;

  // Reference model state, built from the requirements.
  int              mq_cnt [DEP];
  logic [TW-1:0]   mq_tag [DEP];
  logic [BLKW-1:0] mq_dat [DEP];
  int              mq_n = 0;
  logic [BLKW-1:0] mstore [NBK];
  int              cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_ready();
    return !((cyc % PER) == 0) && (mq_n < DEP);
  endfunction

  function automatic int model_pick();
    for (int j = 0; j < mq_n; j++) if (mq_cnt[j] == 0) return j;
    return -1;
  endfunction

  // One cycle: drive, check outputs, advance the model, move to the next cycle.
  task automatic step(input bit rd, input bit wr, input logic [IW-1:0] idx,
                      input logic [TW-1:0] tg, input logic [BLKW-1:0] wd,
                      input bit rr, input string lbl);
    bit exp_rdy;
    int sel;
    logic [BLKW-1:0] snap;
    req_rd = rd; req_wr = wr; req_idx = idx; req_tag = tg; req_wdata = wd;
    rsp_ready = rr;
    #1;
    exp_rdy = model_ready();
    sel = model_pick();
    chk(req_ready === exp_rdy, ((cyc % PER) == 0) ? "R7" : "R6",
        {lbl, " req_ready"}, 64'(req_ready), 64'(exp_rdy));
    chk(rsp_valid === (sel >= 0), lbl, "rsp_valid (R1)", 64'(rsp_valid), 64'(sel >= 0));
    if (sel >= 0) begin
      chk(rsp_tag === mq_tag[sel], lbl, "rsp_tag (R4)", 64'(rsp_tag), 64'(mq_tag[sel]));
      chk(rsp_data === mq_dat[sel], lbl, "rsp_data (R2)", 64'(rsp_data), 64'(mq_dat[sel]));
    end
    snap = mstore[idx];
    if (sel >= 0 && rr) begin
      for (int j = sel; j < mq_n - 1; j++) begin
        mq_cnt[j] = mq_cnt[j+1]; mq_tag[j] = mq_tag[j+1]; mq_dat[j] = mq_dat[j+1];
      end
      mq_n--;
    end
    for (int j = 0; j < mq_n; j++) if (mq_cnt[j] > 0) mq_cnt[j]--;
    if (rd && exp_rdy) begin
      mq_cnt[mq_n] = LAT; mq_tag[mq_n] = tg; mq_dat[mq_n] = snap; mq_n++;
    end
    if (wr && exp_rdy) mstore[idx] = wd;
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit rr, input string lbl);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, '0, rr, lbl);
  endtask

  // Wait for a ready cycle while idle so a directed request is accepted.
  task automatic to_ready(input string lbl);
    for (int k = 0; k < 20 && !model_ready(); k++) step(1'b0, 1'b0, '0, '0, '0, 1'b1, lbl);
  endtask

  initial begin
    for (int b = 0; b < NBK; b++) mstore[b] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid === 1'b0, "R8", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(req_ready === 1'b0, "R8", "req_ready in reset", 64'(req_ready), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: first cycle is a stall slot; unwritten blocks read as zero.
    step(1'b1, 1'b0, 3'd1, 4'h1, '0, 1'b1, "R8");
    to_ready("R8");
    step(1'b1, 1'b0, 3'd6, 4'h2, '0, 1'b1, "R8");
    idle(LAT + 2, 1'b1, "R8");

    // R3: write, no response, then read back.
    to_ready("R3");
    step(1'b0, 1'b1, 3'd3, 4'h0, 32'hA5A5_1234, 1'b1, "R3");
    idle(LAT + 2, 1'b1, "R3");
    to_ready("R3");
    step(1'b1, 1'b0, 3'd3, 4'h3, '0, 1'b1, "R3");
    idle(LAT + 2, 1'b1, "R3");

    // R9: read and write of one block in the same cycle.
    to_ready("R9");
    step(1'b1, 1'b1, 3'd3, 4'h9, 32'h0BAD_F00D, 1'b1, "R9");
    idle(LAT + 2, 1'b1, "R9");

    // R2: a write after a pending read does not alter it.
    to_ready("R2");
    step(1'b1, 1'b0, 3'd3, 4'h4, '0, 1'b1, "R2");
    to_ready("R2");
    step(1'b0, 1'b1, 3'd3, 4'h0, 32'h7777_8888, 1'b1, "R2");
    idle(LAT + 2, 1'b1, "R2");

    // R5: hold a response while later ones expire, then drain.
    to_ready("R5");
    step(1'b1, 1'b0, 3'd3, 4'h5, '0, 1'b0, "R5");
    step(1'b1, 1'b0, 3'd2, 4'h6, '0, 1'b0, "R5");
    idle(LAT + 8, 1'b0, "R5");
    idle(6, 1'b1, "R5");

    // R6: fill the table with reads while nothing is consumed.
    for (int k = 0; k < 3 * DEP + 6; k++)
      step(1'b1, 1'b1, IW'(k), TW'(k), 32'(k * 32'h0101_0101), 1'b0, "R6");
    idle(LAT + 10, 1'b1, "R6");

    // R4: back-to-back reads come out in order.
    to_ready("R4");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, IW'(k), TW'(k + 8), '0, 1'b1, "R4");
    idle(LAT + 8, 1'b1, "R4");

    // R1: seeded random mix with varying pressure.
    void'($urandom(32'd20517));
    for (int k = 0; k < 3000; k++) begin
      int prd, prr;
      prd = (k < 1000) ? 35 : ((k < 2000) ? 80 : 55);
      prr = (k < 1000) ? 90 : ((k < 2000) ? 30 : 70);
      step(($urandom % 100) < prd, ($urandom % 100) < 40, IW'($urandom),
           TW'($urandom), BLKW'($urandom), ($urandom % 100) < prr, "R1");
    end
    idle(LAT + 4 * DEP + 10, 1'b1, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule